// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a shared transfer engine and decides which of eight DMA channels owns the bus next. Each channel picks where its requests come from. It can request on its own at all times, follow an on-chip peripheral line, or follow an external pin. External pins exist only on the lowest channels. A pin can be watched for a level or for an edge. An edge is latched so that a short pulse is not lost while another channel holds the bus.

A winner is chosen by one of two policies. Fixed order favours the lowest channel index. Rotating order demotes the most recently served channel. The engine reports back through two inputs. `unit_done` marks the end of one transfer unit. `chan_done` marks the last unit of the channel's job. In cycle-stealing operation the bus is released after every unit. It is released either at once or after an idle gap of 16 or 64 clocks. In burst operation the channel keeps the bus until its job ends. The acknowledge and end strobes each have their own programmable active level.

Top module: `dmarb_top`

## Requirements
- R1: During and right after reset, `grant` is all zeros and `bus_hold` is low. `ack` and `tend` rest at their inactive levels, which are the inverse of `ack_pol` and of `end_pol`.
- R2: The 4-bit source code of a channel selects its request. Code 0100 requests whenever the channel is active. Code 1000 follows `periph_req` of that channel. Code 0000 follows the channel's external pin, which exists for channels 0 to NEXT-1 only. Any other code, an external code on a channel with no pin, and an inactive channel never produce a grant.
- R3: The 2-bit detect code of a channel sets how its pin raises a request: 00 for a low level, 01 for a high level, 10 for a falling edge, 11 for a rising edge. Each pin passes through a two-flop synchronizer first.
- R4: An edge request stays latched until its channel is granted, even after the pin has returned. A level request is looked at only when an arbitration takes place, so a level that goes away while the bus is busy leaves nothing behind.
- R5: With `rr_mode` low, the pending channel with the lowest index wins.
- R6: With `rr_mode` high, the search starts just after the channel granted last, so that channel has the lowest priority. After reset the search starts at channel 0.
- R7: `grant` is zero or one-hot. `bus_hold` is high exactly when `grant` is non-zero. A grant appears one clock after the arbitration cycle in which the bus is free.
- R8: In normal cycle stealing, `unit_done` drops the grant at the next edge. The following grant can appear one clock later, so there is a single free cycle.
- R9: In burst mode the grant is held through every `unit_done` that comes without `chan_done`. It is released on the `unit_done` that comes with `chan_done`.
- R10: In intermittent cycle stealing, after each unit the grant stays at zero for 16 clocks, or 64 with `gap_long` high, plus one arbitration clock.
- R11: `ack` shows `grant` at the `ack_pol` level. `tend` pulses for one clock, at the `end_pol` level, on the channel whose final unit finished in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_active | input | NCH | Per-channel enable |
| src_sel | input | 4*NCH | Per-channel request source code |
| det_sel | input | 2*NCH | Per-channel pin detect code |
| ext_req | input | NEXT | Asynchronous external request pins |
| periph_req | input | NCH | On-chip peripheral request lines |
| rr_mode | input | 1 | 1 = rotating priority, 0 = fixed |
| burst_mode | input | 1 | 1 = keep bus until job end |
| intermit_mode | input | 1 | 1 = idle gap after each unit (cycle stealing) |
| gap_long | input | 1 | Gap select: 0 = short, 1 = long |
| ack_pol | input | 1 | Active level of `ack` |
| end_pol | input | 1 | Active level of `tend` |
| unit_done | input | 1 | Engine finished one unit |
| chan_done | input | 1 | Finished unit was the last of the job |
| grant | output | NCH | One-hot bus owner |
| ack | output | NCH | Per-channel acknowledge |
| tend | output | NCH | Per-channel transfer-end strobe |
| bus_hold | output | 1 | A channel owns the bus |

## Verification
The bench uses the default parameters: eight channels, four of them with pins, and gaps of 16 and 64 clocks. With eight channels, a rotating pointer that starts from channel 6 has to wrap past channel 7 before it reaches channel 1. Pinless channels 6 and 7 are given the external source code and must stay silent. Both gap lengths are short enough that each free stretch can be counted clock by clock against the exact 17 and 65 cycles expected.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
   typedef enum logic [1:0] {ARB_IDLE, ARB_BUSY, ARB_GAP} arb_state_e;
   localparam logic [3:0] SRC_EXT    = 4'b0000;
   localparam logic [3:0] SRC_AUTO   = 4'b0100;
   localparam logic [3:0] SRC_PERIPH = 4'b1000;
   localparam logic [1:0] DET_LOW  = 2'b00;
   localparam logic [1:0] DET_HIGH = 2'b01;
   localparam logic [1:0] DET_FALL = 2'b10;
   localparam logic [1:0] DET_RISE = 2'b11;
endpackage

// File: rtl/dmarb_sync.sv
module dmarb_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("dmarb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
      end else begin
         st_q[0] <= d;
         for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
      end
   end

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/dmarb_detect.sv
module dmarb_detect
   import dmarb_pkg::*;
#(
   parameter bit HAS_PIN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_s,
   input  logic       periph,
   input  logic       active,
   input  logic [3:0] src,
   input  logic [1:0] det,
   input  logic       take,
   output logic       req
);
   logic ext_hit;

   if (HAS_PIN) begin : g_pin
      logic prev_q, hold_q, edge_seen;

      always_comb begin
         edge_seen = 1'b0;
         if (active && src == SRC_EXT) begin
            if (det == DET_RISE) edge_seen = pin_s & ~prev_q;
            if (det == DET_FALL) edge_seen = ~pin_s & prev_q;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            hold_q <= 1'b0;
         end else begin
            prev_q <= pin_s;
            hold_q <= edge_seen | (hold_q & ~take);
         end
      end

      assign ext_hit = det[1] ? hold_q : (det[0] ? pin_s : ~pin_s);

      // R4
      edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         edge_seen |=> hold_q);
   end else begin : g_nopin
      wire nopin_unused = pin_s ^ take ^ clk ^ rst_n ^ det[0] ^ det[1];
      assign ext_hit = 1'b0;
   end

   assign req = active & ((src == SRC_AUTO) |
                          ((src == SRC_PERIPH) & periph) |
                          ((src == SRC_EXT) & ext_hit));
endmodule

// File: rtl/dmarb_pick.sv
module dmarb_pick #(
   parameter int NCH = 8,
   localparam int IW = $clog2(NCH)
) (
   input  logic [NCH-1:0] pend,
   input  logic [IW-1:0]  last,
   input  logic           rr,
   output logic [NCH-1:0] pick,
   output logic [IW-1:0]  pick_idx
);
   int   base, c;
   logic found;

   always_comb begin
      pick     = '0;
      pick_idx = '0;
      found    = 1'b0;
      base     = rr ? int'(last) : NCH - 1;
      c        = 0;
      for (int k = 1; k <= NCH; k++) begin
         c = (base + k) % NCH;
         if (!found && pend[c]) begin
            found    = 1'b1;
            pick[c]  = 1'b1;
            pick_idx = IW'(c);
         end
      end
   end
endmodule

// File: rtl/dmarb_top.sv
module dmarb_top
   import dmarb_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int NEXT      = 4,
   parameter int GAP_SHORT = 16,
   parameter int GAP_LONG  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    chan_active,
   input  logic [4*NCH-1:0]  src_sel,
   input  logic [2*NCH-1:0]  det_sel,
   input  logic [NEXT-1:0]   ext_req,
   input  logic [NCH-1:0]    periph_req,
   input  logic              rr_mode,
   input  logic              burst_mode,
   input  logic              intermit_mode,
   input  logic              gap_long,
   input  logic              ack_pol,
   input  logic              end_pol,
   input  logic              unit_done,
   input  logic              chan_done,
   output logic [NCH-1:0]    grant,
   output logic [NCH-1:0]    ack,
   output logic [NCH-1:0]    tend,
   output logic              bus_hold
);
   localparam int IW = $clog2(NCH);
   localparam int GW = $clog2(GAP_LONG + 1);
   localparam logic [GW-1:0] GS_M1 = GW'(GAP_SHORT - 1);
   localparam logic [GW-1:0] GL_M1 = GW'(GAP_LONG - 1);

   if (NCH < 2 || NEXT < 1 || NEXT > NCH) begin : g_bad_ch
      $error("dmarb_top: need 2 <= NCH and 1 <= NEXT <= NCH");
   end
   if (GAP_SHORT < 1 || GAP_LONG < GAP_SHORT) begin : g_bad_gap
      $error("dmarb_top: need 1 <= GAP_SHORT <= GAP_LONG");
   end

   arb_state_e     state_q;
   logic [NCH-1:0] grant_q, tend_q, pend, pick, take;
   logic [IW-1:0]  last_q, pick_idx;
   logic [GW-1:0]  gap_q;
   logic [NEXT-1:0] ext_s;

   dmarb_sync #(.W(NEXT), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_req), .q(ext_s));

   assign take = (state_q == ARB_IDLE) ? pick : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i < NEXT) begin : g_pin
         dmarb_detect #(.HAS_PIN(1'b1)) u_det (
            .clk(clk), .rst_n(rst_n), .pin_s(ext_s[i]), .periph(periph_req[i]),
            .active(chan_active[i]), .src(src_sel[4*i +: 4]),
            .det(det_sel[2*i +: 2]), .take(take[i]), .req(pend[i]));
      end else begin : g_nopin
         dmarb_detect #(.HAS_PIN(1'b0)) u_det (
            .clk(clk), .rst_n(rst_n), .pin_s(1'b0), .periph(periph_req[i]),
            .active(chan_active[i]), .src(src_sel[4*i +: 4]),
            .det(det_sel[2*i +: 2]), .take(take[i]), .req(pend[i]));
      end
   end

   dmarb_pick #(.NCH(NCH)) u_pick (
      .pend(pend), .last(last_q), .rr(rr_mode), .pick(pick), .pick_idx(pick_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         grant_q <= '0;
         tend_q  <= '0;
         last_q  <= IW'(NCH - 1);
         gap_q   <= '0;
      end else begin
         tend_q <= '0;
         case (state_q)
            ARB_IDLE: begin
               if (|pend) begin
                  grant_q <= pick;
                  last_q  <= pick_idx;
                  state_q <= ARB_BUSY;
               end
            end
            ARB_BUSY: begin
               if (unit_done) begin
                  if (chan_done) tend_q <= grant_q;
                  if (!burst_mode || chan_done) begin
                     grant_q <= '0;
                     if (!burst_mode && intermit_mode) begin
                        gap_q   <= gap_long ? GL_M1 : GS_M1;
                        state_q <= ARB_GAP;
                     end else begin
                        state_q <= ARB_IDLE;
                     end
                  end
               end
            end
            default: begin
               if (gap_q == '0) state_q <= ARB_IDLE;
               else             gap_q   <= gap_q - 1'b1;
            end
         endcase
      end
   end

   assign grant    = grant_q;
   assign bus_hold = (state_q == ARB_BUSY);
   assign ack      = grant_q ^ {NCH{~ack_pol}};
   assign tend     = tend_q ^ {NCH{~end_pol}};

   // released-time counter used only by the gap check
   logic [GW:0] rel_q;
   logic        seen_rel_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_q      <= '0;
         seen_rel_q <= 1'b0;
      end else begin
         if (bus_hold) rel_q <= '0;
         else if (rel_q <= (GW+1)'(GAP_LONG)) rel_q <= rel_q + 1'b1;
         if ($fell(bus_hold)) seen_rel_q <= 1'b1;
      end
   end

   // R7
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));
   // R7
   hold_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hold == (grant_q != '0));
   // R5
   pick_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_IDLE && pend != '0) |=> (grant_q != '0) && ((grant_q & ~$past(pend)) == '0));
   // R8
   steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold && !burst_mode && unit_done) |=> !bus_hold);
   // R9
   burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold && burst_mode && unit_done && !chan_done) |=> bus_hold && $stable(grant_q));
   // R11
   tend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold && unit_done && chan_done) |=> tend_q == $past(grant_q));
   // R10
   gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_rel_q && $rose(bus_hold) && intermit_mode && !burst_mode) |->
         rel_q >= (gap_long ? (GW+1)'(GAP_LONG) : (GW+1)'(GAP_SHORT)));
endmodule

// File: tb/dmarb_top_test.sv
module dmarb_top_test;
   localparam int NCH  = 8;
   localparam int NEXT = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic [NCH-1:0]    chan_active = '0;
   logic [4*NCH-1:0]  src_sel = '1;
   logic [2*NCH-1:0]  det_sel = '0;
   logic [NEXT-1:0]   ext_req = '0;
   logic [NCH-1:0]    periph_req = '0;
   logic rr_mode = 0, burst_mode = 0, intermit_mode = 0, gap_long = 0;
   logic ack_pol = 1, end_pol = 0, unit_done = 0, chan_done = 0;
   logic [NCH-1:0] grant, ack, tend;
   logic bus_hold;

   dmarb_top uut (
      .clk(clk), .rst_n(rst_n), .chan_active(chan_active), .src_sel(src_sel),
      .det_sel(det_sel), .ext_req(ext_req), .periph_req(periph_req),
      .rr_mode(rr_mode), .burst_mode(burst_mode), .intermit_mode(intermit_mode),
      .gap_long(gap_long), .ack_pol(ack_pol), .end_pol(end_pol),
      .unit_done(unit_done), .chan_done(chan_done), .grant(grant), .ack(ack),
      .tend(tend), .bus_hold(bus_hold));

   int checks = 0, errors = 0;
   int exp_ch[$];
   string exp_tag[$];
   int left[NCH];
   int exp_idle = 0;
   int idle_run = 1000;
   logic [NCH-1:0] end_prev = '0;
   logic [NCH-1:0] grant_prev = '0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int idx_of(logic [NCH-1:0] g);
      for (int i = 0; i < NCH; i++) if (g[i]) return i;
      return -1;
   endfunction

   task automatic expect_grant(int c, string tag);
      exp_ch.push_back(c);
      exp_tag.push_back(tag);
   endtask

   task automatic setup(int c, logic [3:0] s, logic [1:0] d, int units);
      src_sel[4*c +: 4] = s;
      det_sel[2*c +: 2] = d;
      left[c] = units;
   endtask

   task automatic drain();
      while (exp_ch.size() != 0) @(negedge clk);
      repeat (100) @(negedge clk);
   endtask

   // monitor, scoreboard and engine model
   always @(negedge clk) begin
      int c;
      if (rst_n) begin
         // R11 acknowledge level and end strobe
         chk((ack_pol ? ack : ~ack) == grant, "R11", "ack vs grant", int'(ack), int'(grant));
         if ((end_pol ? tend : ~tend) != '0 || end_prev != '0)
            chk((end_pol ? tend : ~tend) == end_prev, "R11", "tend pulse",
                int'(end_pol ? tend : ~tend), int'(end_prev));
         chk(bus_hold == (grant != '0) && $countones(grant) <= 1, "R7", "hold/onehot",
             int'(grant), int'(bus_hold));
         if (grant != '0 && grant_prev == '0) begin
            c = idx_of(grant);
            if (exp_ch.size() == 0) begin
               chk(1'b0, "R7", "unexpected grant", c, -1);
            end else begin
               string t;
               int e;
               e = exp_ch.pop_front();
               t = exp_tag.pop_front();
               chk(c == e, t, "granted channel", c, e);
            end
            if (exp_idle > 0 && idle_run < 100)
               chk(idle_run == exp_idle, exp_idle == 1 ? "R8" : "R10", "free cycles",
                   idle_run, exp_idle);
         end
         idle_run   = (grant == '0) ? idle_run + 1 : 0;
         grant_prev = grant;
         end_prev   = '0;
         if (unit_done) begin
            unit_done = 1'b0;
            chan_done = 1'b0;
         end else if (grant != '0) begin
            c = idx_of(grant);
            unit_done = 1'b1;
            if (left[c] <= 1) begin
               chan_done = 1'b1;
               chan_active[c] = 1'b0;
               end_prev = grant;
            end
            left[c]--;
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) left[i] = 1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(grant == '0 && !bus_hold, "R1", "grant in reset", int'(grant), 0);
      chk(ack == '0, "R1", "ack idle level", int'(ack), 0);
      chk(tend == '1, "R1", "tend idle level", int'(tend), 255);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(grant == '0 && tend == '1, "R1", "after reset", int'(grant), 0);

      // R5 fixed priority, normal cycle stealing
      setup(5, 4'b0100, 2'b00, 1); setup(2, 4'b0100, 2'b00, 1); setup(6, 4'b0100, 2'b00, 1);
      expect_grant(2, "R5"); expect_grant(5, "R5"); expect_grant(6, "R5");
      exp_idle = 1;
      chan_active[5] = 1; chan_active[2] = 1; chan_active[6] = 1;
      drain();

      // R6 rotating priority, flipped polarities
      rr_mode = 1; ack_pol = 0; end_pol = 1;
      setup(1, 4'b0100, 2'b00, 2); setup(3, 4'b0100, 2'b00, 2);
      expect_grant(1, "R6"); expect_grant(3, "R6"); expect_grant(1, "R6"); expect_grant(3, "R6");
      chan_active[1] = 1; chan_active[3] = 1;
      drain();
      rr_mode = 0; exp_idle = 0;

      // R9 burst keeps bus for a whole job
      burst_mode = 1;
      setup(0, 4'b0100, 2'b00, 1); setup(4, 4'b0100, 2'b00, 3);
      expect_grant(0, "R9"); expect_grant(4, "R9");
      chan_active[0] = 1; chan_active[4] = 1;
      drain();

      // R4 edge latched, level dropped while bus busy
      setup(0, 4'b0100, 2'b00, 10); setup(2, 4'b0000, 2'b01, 1); setup(3, 4'b0000, 2'b11, 1);
      expect_grant(0, "R4"); expect_grant(3, "R4");
      chan_active[0] = 1; chan_active[2] = 1; chan_active[3] = 1;
      repeat (4) @(negedge clk);
      ext_req[2] = 1; ext_req[3] = 1;
      repeat (4) @(negedge clk);
      ext_req[2] = 0;
      drain();
      chk(chan_active[2] == 1'b1, "R4", "stale level not granted", 0, 0);
      chan_active[2] = 0; burst_mode = 0; ext_req[3] = 0;
      repeat (10) @(negedge clk);

      // R3 low level and falling edge
      ext_req[0] = 1; ext_req[1] = 1;
      repeat (5) @(negedge clk);
      setup(1, 4'b0000, 2'b00, 1); setup(0, 4'b0000, 2'b10, 1);
      chan_active[0] = 1; chan_active[1] = 1;
      repeat (20) @(negedge clk);
      chk(grant == '0 && !bus_hold, "R3", "no request before pin moves", int'(grant), 0);
      expect_grant(0, "R3");
      ext_req[0] = 0;
      drain();
      expect_grant(1, "R3");
      ext_req[1] = 0;
      drain();

      // R2 ignored sources
      setup(2, 4'b1000, 2'b01, 1); setup(6, 4'b0000, 2'b01, 1); setup(7, 4'b0011, 2'b01, 1);
      ext_req[2] = 1;
      chan_active[2] = 1; chan_active[6] = 1; chan_active[7] = 1;
      repeat (30) @(negedge clk);
      chk(grant == '0 && !bus_hold, "R2", "pin on peripheral channel", int'(grant), 0);
      periph_req[6] = 1; periph_req[7] = 1;
      repeat (30) @(negedge clk);
      chk(grant == '0 && !bus_hold, "R2", "pinless/unknown codes", int'(grant), 0);
      expect_grant(2, "R2");
      periph_req[2] = 1;
      drain();
      chan_active[6] = 0; chan_active[7] = 0; periph_req = '0; ext_req = '0;

      // R10 intermittent gaps
      intermit_mode = 1; gap_long = 0; exp_idle = 17;
      setup(3, 4'b0100, 2'b00, 3);
      expect_grant(3, "R10"); expect_grant(3, "R10"); expect_grant(3, "R10");
      chan_active[3] = 1;
      drain();
      gap_long = 1; exp_idle = 65;
      setup(5, 4'b0100, 2'b00, 2);
      expect_grant(5, "R10"); expect_grant(5, "R10");
      chan_active[5] = 1;
      drain();
      intermit_mode = 0; exp_idle = 0;

      chk(exp_ch.size() == 0, "R7", "grants outstanding", exp_ch.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule